// File: doc/BRIEF.md
# Two-Level Interrupt Status Controller

This block gathers interrupt events from a set of transmit queues and from a handful of miscellaneous sources, and presents them to software in two levels. Five secondary status registers hold one bit per queue and per cause. A primary status register shows one bit per event class. An aggregated primary bit is the live OR of its group of secondary bits, and a few stand-alone events are stored directly in the primary register. A primary mask, a secondary mask for the underrun, host-error and beacon causes, and a global enable together decide whether the single interrupt line is raised.

Software uses a single-cycle register port. A write with `reg_we` high takes effect at the next clock edge. `reg_rdata` is a combinational view of the register selected by `reg_addr`. All status registers are write-one-to-clear. Writing 1 to an aggregated primary bit wipes every secondary bit of that group. A handler that must not lose events arriving during servicing should therefore clear the secondary registers first and never write aggregated bits back to the primary register. The register port has no back-pressure: every write is accepted in the cycle it is presented, and event inputs are single-cycle pulses with no handshake.

Register map (address: content): 0 primary status; 1 primary mask; 2..6 secondary status 0..4; 7 secondary mask for register 2; 8 global enable (bit 0); 9 pending (bit 0, read only). Primary bits: 0 rx-ok, 1 rx-error, 2 tx-ok, 3 tx-desc, 4 tx-error, 5 tx-end-of-list, 6 tx-underrun, 7 host-error, 8 beacon-misc, 9 rate overrun, 10 rate underrun, 11 queue trigger, 12 beacon-not-ready. Secondary layouts, with Q = NQ queues:
- Register 0: tx-ok in [Q-1:0], tx-desc in [2Q-1:Q].
- Register 1: tx-error in [Q-1:0], end-of-list in [2Q-1:Q].
- Register 2: underrun in [Q-1:0]; master abort, system error and parity in [Q+2:Q]; TIM, DTIM, DTIM-sync, beacon timeout and CAB timeout in [Q+7:Q+3].
- Register 3: overrun in [Q-1:0], underrun in [2Q-1:Q].
- Register 4: trigger in [Q-1:0].

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, every status, mask and enable register reads 0, and `irq` and `pending` are 0.
- R2: An event pulse sets its own secondary bit at the position given in the layout above, and the bit can be read in the cycle after the pulse.
- R3: Each aggregated primary bit reads as the OR of its secondary group. The groups in register 2 are first ANDed with the secondary mask. The primary bit reads 0 once every bit of its group is clear.
- R4: A write to a secondary status register clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R5: Writing 1 to an aggregated primary bit clears every secondary bit of its group and leaves all other groups unchanged.
- R6: If an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R7: rx-ok, rx-error and beacon-not-ready events set primary bits 0, 1 and 12 directly, and those bits are write-one-to-clear.
- R8: The secondary mask enables each underrun queue bit, each host-error cause and each beacon cause separately, on its bit position in register 2.
- R9: `pending`, and bit 0 at address 9, are 1 exactly when the global enable is set and some primary status bit has its primary mask bit set.
- R10: `irq` equals the value `pending` had one cycle earlier.
- R11: The primary mask, secondary mask and global enable read back the value last written, truncated to their widths (13, NQ+8 and 1 bits).
- R12: Addresses 10 to 15 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_rx_ok | input | 1 | Receive-done pulse |
| ev_rx_err | input | 1 | Receive-error pulse |
| ev_bcn_notrdy | input | 1 | Beacon-not-ready pulse |
| ev_txok | input | NQ | Per-queue transmit-ok pulses |
| ev_txdesc | input | NQ | Per-queue descriptor-done pulses |
| ev_txerr | input | NQ | Per-queue transmit-error pulses |
| ev_txeol | input | NQ | Per-queue end-of-list pulses |
| ev_txurn | input | NQ | Per-queue underrun pulses |
| ev_hif_err | input | 3 | Master abort, system error, parity error |
| ev_bcn | input | 5 | TIM, DTIM, DTIM-sync, beacon timeout, CAB timeout |
| ev_cbr_over | input | NQ | Per-queue rate overrun pulses |
| ev_cbr_under | input | NQ | Per-queue rate underrun pulses |
| ev_qtrig | input | NQ | Per-queue trigger pulses |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| irq | output | 1 | Registered interrupt line |
| pending | output | 1 | Live masked-and-enabled interrupt flag |

## Verification
The bench builds the block with its default of ten queues and a 32-bit data path. At this size the widest secondary groups (twenty bits) use the upper half of the data path, and the top queue index lands in every group slice, so boundary positions such as bit 19 of register 0 and the mask field at bits 10 to 17 of register 2 are exercised. A behavioural model keeps one bit per queue and per cause and is compared with the read data, `pending` and `irq` on every clock. This covers directed sequences and a long stretch of random event pulses mixed with random writes.

// File: rtl/isc_pkg.sv
package isc_pkg;
  // register addresses
  localparam int A_PRIM  = 0;
  localparam int A_PMASK = 1;
  localparam int A_SEC0  = 2;
  localparam int A_SEC4  = 6;
  localparam int A_SMASK = 7;
  localparam int A_GEN   = 8;
  localparam int A_PEND  = 9;
  localparam int A_LAST  = 9;

  // primary bit positions
  localparam int P_RXOK   = 0;
  localparam int P_RXERR  = 1;
  localparam int P_TXOK   = 2;
  localparam int P_TXDESC = 3;
  localparam int P_TXERR  = 4;
  localparam int P_TXEOL  = 5;
  localparam int P_TXURN  = 6;
  localparam int P_HIU    = 7;
  localparam int P_BCN    = 8;
  localparam int P_CBRO   = 9;
  localparam int P_CBRU   = 10;
  localparam int P_TRIG   = 11;
  localparam int P_BNR    = 12;
  localparam int PW       = 13;

  localparam int NHIF = 3;
  localparam int NBCN = 5;
  localparam int NSEC = 5;
endpackage

// File: rtl/isc_w1c_reg.sv
module isc_w1c_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // set has priority over clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/isc_aggregate.sv
module isc_aggregate
  import isc_pkg::*;
#(
  parameter int NQ = 10,
  parameter int SW = 20,
  parameter int MW = 18
) (
  input  logic [SW-1:0] sec0_i,
  input  logic [SW-1:0] sec1_i,
  input  logic [SW-1:0] sec2_i,
  input  logic [SW-1:0] sec3_i,
  input  logic [SW-1:0] sec4_i,
  input  logic [MW-1:0] smask_i,
  output logic [PW-1:0] agg_o
);
  localparam int HLO = NQ;
  localparam int BLO = NQ + NHIF;

  logic [MW-1:0] s2_masked;
  assign s2_masked = sec2_i[MW-1:0] & smask_i;

  always_comb begin
    agg_o           = '0;
    agg_o[P_TXOK]   = |sec0_i[NQ-1:0];
    agg_o[P_TXDESC] = |sec0_i[2*NQ-1:NQ];
    agg_o[P_TXERR]  = |sec1_i[NQ-1:0];
    agg_o[P_TXEOL]  = |sec1_i[2*NQ-1:NQ];
    agg_o[P_TXURN]  = |s2_masked[NQ-1:0];
    agg_o[P_HIU]    = |s2_masked[HLO+NHIF-1:HLO];
    agg_o[P_BCN]    = |s2_masked[BLO+NBCN-1:BLO];
    agg_o[P_CBRO]   = |sec3_i[NQ-1:0];
    agg_o[P_CBRU]   = |sec3_i[2*NQ-1:NQ];
    agg_o[P_TRIG]   = |sec4_i[NQ-1:0];
  end
endmodule

// File: rtl/isc_irq_out.sv
module isc_irq_out
  import isc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] prim_i,
  input  logic [PW-1:0] pmask_i,
  input  logic          gen_i,
  output logic          pending_o,
  output logic          irq_o
);
  assign pending_o = gen_i & (|(prim_i & pmask_i));

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pending_o;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import isc_pkg::*;
#(
  parameter int NQ = 10,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_rx_ok,
  input  logic          ev_rx_err,
  input  logic          ev_bcn_notrdy,
  input  logic [NQ-1:0] ev_txok,
  input  logic [NQ-1:0] ev_txdesc,
  input  logic [NQ-1:0] ev_txerr,
  input  logic [NQ-1:0] ev_txeol,
  input  logic [NQ-1:0] ev_txurn,
  input  logic [2:0]    ev_hif_err,
  input  logic [4:0]    ev_bcn,
  input  logic [NQ-1:0] ev_cbr_over,
  input  logic [NQ-1:0] ev_cbr_under,
  input  logic [NQ-1:0] ev_qtrig,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          pending
);
  localparam int MW  = NQ + NHIF + NBCN;
  localparam int SW  = (2 * NQ > MW) ? 2 * NQ : MW;
  localparam int HLO = NQ;
  localparam int BLO = NQ + NHIF;

  logic [SW-1:0] sec_set [NSEC];
  logic [SW-1:0] sec_clr [NSEC];
  logic [SW-1:0] sec_q   [NSEC];
  logic [PW-1:0] pwr;
  logic [2:0]    dir_set, dir_clr, dir_q;
  logic [PW-1:0] agg;
  logic [PW-1:0] prim_val;
  logic [PW-1:0] pmask_q;
  logic [MW-1:0] smask_q;
  logic          gen_q;

  // write-one-to-clear data aimed at the primary register
  assign pwr = (reg_we && reg_addr == AW'(A_PRIM)) ? reg_wdata[PW-1:0] : '0;

  always_comb begin
    for (int k = 0; k < NSEC; k++) begin
      sec_set[k] = '0;
      sec_clr[k] = (reg_we && reg_addr == AW'(A_SEC0 + k)) ? reg_wdata[SW-1:0] : '0;
    end
    sec_set[0][NQ-1:0]           = ev_txok;
    sec_set[0][2*NQ-1:NQ]        = ev_txdesc;
    sec_set[1][NQ-1:0]           = ev_txerr;
    sec_set[1][2*NQ-1:NQ]        = ev_txeol;
    sec_set[2][NQ-1:0]           = ev_txurn;
    sec_set[2][HLO+NHIF-1:HLO]   = ev_hif_err;
    sec_set[2][BLO+NBCN-1:BLO]   = ev_bcn;
    sec_set[3][NQ-1:0]           = ev_cbr_over;
    sec_set[3][2*NQ-1:NQ]        = ev_cbr_under;
    sec_set[4][NQ-1:0]           = ev_qtrig;
    // group clears driven by aggregated primary bits
    sec_clr[0][NQ-1:0]         = sec_clr[0][NQ-1:0]         | {NQ{pwr[P_TXOK]}};
    sec_clr[0][2*NQ-1:NQ]      = sec_clr[0][2*NQ-1:NQ]      | {NQ{pwr[P_TXDESC]}};
    sec_clr[1][NQ-1:0]         = sec_clr[1][NQ-1:0]         | {NQ{pwr[P_TXERR]}};
    sec_clr[1][2*NQ-1:NQ]      = sec_clr[1][2*NQ-1:NQ]      | {NQ{pwr[P_TXEOL]}};
    sec_clr[2][NQ-1:0]         = sec_clr[2][NQ-1:0]         | {NQ{pwr[P_TXURN]}};
    sec_clr[2][HLO+NHIF-1:HLO] = sec_clr[2][HLO+NHIF-1:HLO] | {NHIF{pwr[P_HIU]}};
    sec_clr[2][BLO+NBCN-1:BLO] = sec_clr[2][BLO+NBCN-1:BLO] | {NBCN{pwr[P_BCN]}};
    sec_clr[3][NQ-1:0]         = sec_clr[3][NQ-1:0]         | {NQ{pwr[P_CBRO]}};
    sec_clr[3][2*NQ-1:NQ]      = sec_clr[3][2*NQ-1:NQ]      | {NQ{pwr[P_CBRU]}};
    sec_clr[4][NQ-1:0]         = sec_clr[4][NQ-1:0]         | {NQ{pwr[P_TRIG]}};
  end

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    isc_w1c_reg #(.W(SW)) u_sec (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (sec_set[g]),
      .clr_i (sec_clr[g]),
      .q_o   (sec_q[g])
    );
  end

  assign dir_set = {ev_bcn_notrdy, ev_rx_err, ev_rx_ok};
  assign dir_clr = {pwr[P_BNR], pwr[P_RXERR], pwr[P_RXOK]};

  isc_w1c_reg #(.W(3)) u_direct (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (dir_set),
    .clr_i (dir_clr),
    .q_o   (dir_q)
  );

  isc_aggregate #(.NQ(NQ), .SW(SW), .MW(MW)) u_agg (
    .sec0_i  (sec_q[0]),
    .sec1_i  (sec_q[1]),
    .sec2_i  (sec_q[2]),
    .sec3_i  (sec_q[3]),
    .sec4_i  (sec_q[4]),
    .smask_i (smask_q),
    .agg_o   (agg)
  );

  always_comb begin
    prim_val          = agg;
    prim_val[P_RXOK]  = dir_q[0];
    prim_val[P_RXERR] = dir_q[1];
    prim_val[P_BNR]   = dir_q[2];
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pmask_q <= '0;
      smask_q <= '0;
      gen_q   <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == AW'(A_PMASK)) pmask_q <= reg_wdata[PW-1:0];
      if (reg_addr == AW'(A_SMASK)) smask_q <= reg_wdata[MW-1:0];
      if (reg_addr == AW'(A_GEN))   gen_q   <= reg_wdata[0];
    end
  end

  isc_irq_out u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .prim_i    (prim_val),
    .pmask_i   (pmask_q),
    .gen_i     (gen_q),
    .pending_o (pending),
    .irq_o     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_PRIM))       reg_rdata = DW'(prim_val);
    else if (reg_addr == AW'(A_PMASK)) reg_rdata = DW'(pmask_q);
    else if (reg_addr == AW'(A_SMASK)) reg_rdata = DW'(smask_q);
    else if (reg_addr == AW'(A_GEN))   reg_rdata = DW'(gen_q);
    else if (reg_addr == AW'(A_PEND))  reg_rdata = DW'(pending);
    else begin
      for (int k = 0; k < NSEC; k++)
        if (reg_addr == AW'(A_SEC0 + k)) reg_rdata = DW'(sec_q[k]);
    end
  end
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
  import isc_pkg::*;
#(
  parameter int NQ = 10,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          pending,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          gen_q,
  input logic [PW-1:0] prim_val,
  input logic          ev_rx_ok,
  input logic [NQ-1:0] ev_txok
);
  assert_irq_lags_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(pending));

  assert_enable_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |-> !pending);

  assert_event_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_ok |=> prim_val[P_RXOK]);

  assert_group_wipe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(A_PRIM) && reg_wdata[P_TXOK] && ev_txok == '0)
      |=> !prim_val[P_TXOK]);

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > AW'(A_LAST)) |-> reg_rdata == '0);
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.NQ(NQ), .AW(AW), .DW(DW)) chk_i (.*);

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 10;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int MW = NQ + 8;

  logic clk = 0, rst_n = 0;
  logic ev_rx_ok, ev_rx_err, ev_bcn_notrdy;
  logic [NQ-1:0] ev_txok, ev_txdesc, ev_txerr, ev_txeol, ev_txurn;
  logic [NQ-1:0] ev_cbr_over, ev_cbr_under, ev_qtrig;
  logic [2:0] ev_hif_err;
  logic [4:0] ev_bcn;
  logic reg_we;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic irq, pending;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl #(.NQ(NQ), .AW(AW), .DW(DW)) dut_i (.*);

  // behavioural reference: one bit per queue and cause
  bit m_ok[NQ], m_desc[NQ], m_err[NQ], m_eol[NQ], m_urn[NQ];
  bit m_co[NQ], m_cu[NQ], m_tr[NQ];
  bit m_hif[3], m_bcn[5];
  bit m_rxok, m_rxerr, m_bnr, m_gen, m_irq;
  bit [12:0] m_pmask;
  bit [MW-1:0] m_smask;

  int n_checks = 0, n_fail = 0;
  string cur_req = "R1";

  function automatic bit any_of(input bit a[NQ]);
    for (int i = 0; i < NQ; i++) if (a[i]) return 1;
    return 0;
  endfunction

  function automatic bit [12:0] m_prim();
    bit [12:0] p = 0;
    bit u = 0, h = 0, b = 0;
    for (int i = 0; i < NQ; i++) if (m_urn[i] && m_smask[i]) u = 1;
    for (int i = 0; i < 3; i++) if (m_hif[i] && m_smask[NQ+i]) h = 1;
    for (int i = 0; i < 5; i++) if (m_bcn[i] && m_smask[NQ+3+i]) b = 1;
    p[0] = m_rxok; p[1] = m_rxerr; p[12] = m_bnr;
    p[2] = any_of(m_ok); p[3] = any_of(m_desc);
    p[4] = any_of(m_err); p[5] = any_of(m_eol);
    p[6] = u; p[7] = h; p[8] = b;
    p[9] = any_of(m_co); p[10] = any_of(m_cu); p[11] = any_of(m_tr);
    return p;
  endfunction

  function automatic bit m_pend();
    return m_gen && ((m_prim() & m_pmask) != 0);
  endfunction

  function automatic bit [DW-1:0] m_read(input int a);
    bit [DW-1:0] r = 0;
    case (a)
      0: r = DW'(m_prim());
      1: r = DW'(m_pmask);
      2: for (int i = 0; i < NQ; i++) begin r[i] = m_ok[i];  r[NQ+i] = m_desc[i]; end
      3: for (int i = 0; i < NQ; i++) begin r[i] = m_err[i]; r[NQ+i] = m_eol[i]; end
      4: begin
           for (int i = 0; i < NQ; i++) r[i] = m_urn[i];
           for (int i = 0; i < 3; i++) r[NQ+i] = m_hif[i];
           for (int i = 0; i < 5; i++) r[NQ+3+i] = m_bcn[i];
         end
      5: for (int i = 0; i < NQ; i++) begin r[i] = m_co[i]; r[NQ+i] = m_cu[i]; end
      6: for (int i = 0; i < NQ; i++) r[i] = m_tr[i];
      7: r = DW'(m_smask);
      8: r = DW'(m_gen);
      9: r = DW'(m_pend());
      default: r = 0;
    endcase
    return r;
  endfunction

  // model update on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) begin
        m_ok[i]=0; m_desc[i]=0; m_err[i]=0; m_eol[i]=0; m_urn[i]=0;
        m_co[i]=0; m_cu[i]=0; m_tr[i]=0;
      end
      for (int i = 0; i < 3; i++) m_hif[i] = 0;
      for (int i = 0; i < 5; i++) m_bcn[i] = 0;
      m_rxok=0; m_rxerr=0; m_bnr=0; m_gen=0; m_irq=0; m_pmask=0; m_smask=0;
    end else begin
      bit [DW-1:0] w;
      int a;
      m_irq = m_pend();
      w = reg_we ? reg_wdata : '0;
      a = int'(reg_addr);
      // clears first, events afterwards so events win
      if (a == 0) begin
        if (w[0]) m_rxok = 0;
        if (w[1]) m_rxerr = 0;
        if (w[12]) m_bnr = 0;
        for (int i = 0; i < NQ; i++) begin
          if (w[2]) m_ok[i] = 0;   if (w[3]) m_desc[i] = 0;
          if (w[4]) m_err[i] = 0;  if (w[5]) m_eol[i] = 0;
          if (w[6]) m_urn[i] = 0;  if (w[9]) m_co[i] = 0;
          if (w[10]) m_cu[i] = 0;  if (w[11]) m_tr[i] = 0;
        end
        for (int i = 0; i < 3; i++) if (w[7]) m_hif[i] = 0;
        for (int i = 0; i < 5; i++) if (w[8]) m_bcn[i] = 0;
      end
      for (int i = 0; i < NQ; i++) begin
        if (a == 2 && w[i]) m_ok[i] = 0;   if (a == 2 && w[NQ+i]) m_desc[i] = 0;
        if (a == 3 && w[i]) m_err[i] = 0;  if (a == 3 && w[NQ+i]) m_eol[i] = 0;
        if (a == 4 && w[i]) m_urn[i] = 0;
        if (a == 5 && w[i]) m_co[i] = 0;   if (a == 5 && w[NQ+i]) m_cu[i] = 0;
        if (a == 6 && w[i]) m_tr[i] = 0;
      end
      for (int i = 0; i < 3; i++) if (a == 4 && w[NQ+i]) m_hif[i] = 0;
      for (int i = 0; i < 5; i++) if (a == 4 && w[NQ+3+i]) m_bcn[i] = 0;
      if (reg_we && a == 1) m_pmask = reg_wdata[12:0];
      if (reg_we && a == 7) m_smask = reg_wdata[MW-1:0];
      if (reg_we && a == 8) m_gen = reg_wdata[0];
      for (int i = 0; i < NQ; i++) begin
        if (ev_txok[i]) m_ok[i] = 1;     if (ev_txdesc[i]) m_desc[i] = 1;
        if (ev_txerr[i]) m_err[i] = 1;   if (ev_txeol[i]) m_eol[i] = 1;
        if (ev_txurn[i]) m_urn[i] = 1;   if (ev_cbr_over[i]) m_co[i] = 1;
        if (ev_cbr_under[i]) m_cu[i] = 1; if (ev_qtrig[i]) m_tr[i] = 1;
      end
      for (int i = 0; i < 3; i++) if (ev_hif_err[i]) m_hif[i] = 1;
      for (int i = 0; i < 5; i++) if (ev_bcn[i]) m_bcn[i] = 1;
      if (ev_rx_ok) m_rxok = 1;
      if (ev_rx_err) m_rxerr = 1;
      if (ev_bcn_notrdy) m_bnr = 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "rdata", reg_rdata, m_read(int'(reg_addr)));
      chk((cur_req == "R10") ? "R10" : cur_req, "irq", DW'(irq), DW'(m_irq));
      chk((cur_req == "R9") ? "R9" : cur_req, "pending", DW'(pending), DW'(m_pend()));
    end
  end

  task automatic idle_ins();
    ev_rx_ok = 0; ev_rx_err = 0; ev_bcn_notrdy = 0;
    ev_txok = 0; ev_txdesc = 0; ev_txerr = 0; ev_txeol = 0; ev_txurn = 0;
    ev_cbr_over = 0; ev_cbr_under = 0; ev_qtrig = 0; ev_hif_err = 0; ev_bcn = 0;
    reg_we = 0;
  endtask

  task automatic tick();
    @(negedge clk); #1;
    idle_ins();
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    tick(); reg_we = 1; reg_addr = AW'(a); reg_wdata = d;
  endtask

  task automatic rd_expect(input int a, input logic [DW-1:0] exp, input string req);
    tick(); reg_addr = AW'(a);
    @(negedge clk);
    chk(req, "read", reg_rdata, exp);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    idle_ins(); reg_addr = 0; reg_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1
    cur_req = "R1";
    @(negedge clk);
    chk("R1", "irq", DW'(irq), 0);
    chk("R1", "pending", DW'(pending), 0);
    for (int a = 0; a < 10; a++) rd_expect(a, 0, "R1");
    // R11
    cur_req = "R11";
    wr(1, 32'hFFFF_FFFF); rd_expect(1, 32'h1FFF, "R11");
    wr(7, 32'hFFFF_FFFF); rd_expect(7, 32'h3FFFF, "R11");
    wr(8, 32'hFFFF_FFFE); rd_expect(8, 0, "R11");
    wr(1, 0); wr(7, 0);
    // R2
    cur_req = "R2";
    tick(); ev_txok[3] = 1;
    rd_expect(2, 32'h8, "R2");
    rd_expect(0, 32'h4, "R2");
    // R3 and R4
    cur_req = "R3";
    tick(); ev_txdesc[9] = 1;
    rd_expect(0, 32'hC, "R3");
    cur_req = "R4";
    wr(2, 32'h8);
    rd_expect(2, 32'h80000, "R4");
    rd_expect(0, 32'h8, "R3");
    // R5
    cur_req = "R5";
    tick(); ev_txerr[1] = 1; ev_txeol[2] = 1; ev_qtrig[5] = 1;
    wr(0, 32'h10);
    rd_expect(3, 32'h1000, "R5");
    rd_expect(6, 32'h20, "R5");
    // R6
    cur_req = "R6";
    wr(3, 32'hFFFFF); ev_txerr[1] = 1;
    rd_expect(3, 32'h2, "R6");
    wr(0, 32'h1); ev_rx_ok = 1;
    rd_expect(0, 32'h1 | 32'h8 | 32'h10 | 32'h800, "R6");
    // R7
    cur_req = "R7";
    tick(); ev_bcn_notrdy = 1; ev_rx_err = 1;
    wr(0, 32'h1);
    rd_expect(0, 32'h1002 | 32'h8 | 32'h10 | 32'h800, "R7");
    wr(0, 32'h1002);
    rd_expect(0, 32'h818, "R7");
    // R8
    cur_req = "R8";
    wr(7, (32'h1 << 4) | (32'h1 << (NQ+1)));
    tick(); ev_txurn[4] = 1; ev_txurn[5] = 1; ev_hif_err = 3'b111; ev_bcn = 5'b11111;
    rd_expect(4, 32'h3FC30, "R8");
    rd_expect(0, 32'h8D8, "R8");
    wr(7, (32'h1 << 4) | (32'h1 << (NQ+1)) | (32'h1 << (NQ+5)));
    rd_expect(0, 32'h9D8, "R8");
    wr(4, 32'h10);
    rd_expect(0, 32'h998, "R8");
    // R9 / R10
    cur_req = "R9";
    wr(1, 32'h1FFF);
    rd_expect(9, 0, "R9");
    wr(8, 1);
    rd_expect(9, 1, "R9");
    cur_req = "R10";
    @(negedge clk); chk("R10", "irq", DW'(irq), 1);
    wr(1, 0);
    @(negedge clk); chk("R9", "pending", DW'(pending), 0);
    @(negedge clk); chk("R10", "irq", DW'(irq), 0);
    // R12
    cur_req = "R12";
    for (int a = 10; a < 16; a++) begin wr(a, 32'hFFFF_FFFF); rd_expect(a, 0, "R12"); end
    rd_expect(1, 0, "R12");
    rd_expect(8, 1, "R12");
    rd_expect(0, 32'h998, "R12");
    // random mix
    cur_req = "R3";
    for (int c = 0; c < 3000; c++) begin
      tick();
      if ($urandom_range(0, 3) == 0) begin
        ev_txok = NQ'($urandom & $urandom); ev_txdesc = NQ'($urandom & $urandom);
        ev_txerr = NQ'($urandom & $urandom); ev_txeol = NQ'($urandom & $urandom);
        ev_txurn = NQ'($urandom & $urandom); ev_cbr_over = NQ'($urandom & $urandom);
        ev_cbr_under = NQ'($urandom & $urandom); ev_qtrig = NQ'($urandom & $urandom);
        ev_hif_err = 3'($urandom); ev_bcn = 5'($urandom);
        ev_rx_ok = 1'($urandom); ev_rx_err = 1'($urandom); ev_bcn_notrdy = 1'($urandom);
      end
      reg_addr = AW'($urandom_range(0, 15));
      if ($urandom_range(0, 2) == 0) begin
        reg_we = 1; reg_wdata = $urandom;
      end
    end
    tick();
    @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule